// File: doc/BRIEF.md
# Segmentation header replay inserter

The block accepts one transmit job at a time on a byte stream. A job opens with a prototype header, whose first byte is flagged by a start-of-job marker. The payload follows as a long byte stream. The header bytes are written into an internal store and are not sent on by themselves. The payload is then cut into segments of no more than the configured maximum segment size. Each segment goes out as its own frame, made of a fresh copy of the stored header followed by that segment's payload bytes. The last segment carries whatever payload is left.

Both streams use valid/ready handshaking. A byte moves when valid and ready are both high at a rising clock edge. When the sink lowers ready, the block holds its output byte and its sideband flags steady. While a header is being replayed, the block keeps the input ready low. A payload burst that arrives without gaps can therefore cross a segment boundary: the input stalls for the length of the header, then resumes with the next byte, and no byte is lost or reordered. With each frame the block presents a segment index and a last-segment flag, so that a later stage can rewrite the header fields. This block does not change the header contents.

The header length, segment size and total payload length are sampled when the first header byte is accepted. After the total payload has been emitted, the block returns to waiting for the next job.

Top module: `seg_hdr_replay`

## Requirements
- R1: Header bytes of a job are captured and never appear on the output until the whole header (cfg_hdr_len bytes) has been accepted.
- R2: Every segment frame starts with all cfg_hdr_len stored header bytes in arrival order, and out_sof is high only on the first of them.
- R3: Each segment carries min(cfg_mss, remaining) payload bytes, so the final segment carries the remainder. out_eof is high only on a segment's last payload byte.
- R4: Payload bytes leave in arrival order with none lost or duplicated, including when one unbroken input burst spans several segments.
- R5: While header bytes are being replayed, in_ready is low.
- R6: out_seg_idx is 0 for the first segment of a job and rises by one per segment. out_last_seg is high for every byte of the final segment and low otherwise.
- R7: cfg_err is high when cfg_hdr_len is 0 or above HDR_MAX (128), or when cfg_mss is 0. While it is high and the block is idle, in_ready is low and no job starts.
- R8: After cfg_total payload bytes have been emitted, the block is idle: out_valid is low and in_ready is high. A job with cfg_total = 0 captures its header and emits no frame.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R10: Bytes that arrive while the block is idle and that lack in_first are accepted and dropped, and produce no output.
- R11: After reset, out_valid is low and in_ready is high when the configuration is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hdr_len | input | LEN_W (8) | Header length in bytes, 1..HDR_MAX |
| cfg_mss | input | CNT_W (16) | Maximum payload bytes per segment |
| cfg_total | input | CNT_W (16) | Total payload bytes of the job |
| cfg_err | output | 1 | Configuration out of range |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Marks the first header byte of a job |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink ready |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First header byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |
| out_seg_idx | output | IDX_W (8) | Segment index within the job |
| out_last_seg | output | 1 | Frame is the job's final segment |

## Verification
Two events can fall in the same cycle: the end of a segment and the end of the whole job. This happens when the total is an exact multiple of the segment size, and the block must then go idle instead of starting another header replay. The sweep covers header lengths, segment sizes and totals from 0 to 9 bytes, so exact multiples and remainders are both reached, under random gaps in input valid and output ready. Every output byte is compared with an expected frame list computed arithmetically. After the job, the bench checks that the block is idle and accepts the next job's marker at once.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_HDR  = 2'd2,
    ST_PAY  = 2'd3
  } shr_state_t;
endpackage

// File: rtl/shr_hdr_mem.sv
module shr_hdr_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/shr_seg_track.sv
module shr_seg_track #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] mss_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             pay_fire,
  output logic             seg_end,
  output logic             job_end,
  output logic             job_empty,
  output logic             last_seg,
  output logic [IDX_W-1:0] seg_idx
);
  logic [CNT_W-1:0] rem_q, segcnt_q, mss_q;
  logic [IDX_W-1:0] idx_q;

  // bytes left at segment start = rem + bytes already sent in this segment
  assign last_seg  = ({1'b0, rem_q} + {1'b0, segcnt_q}) <= {1'b0, mss_q};
  assign job_end   = (rem_q == CNT_W'(1));
  assign job_empty = (rem_q == '0);
  assign seg_end   = (segcnt_q == mss_q - CNT_W'(1)) || job_end;
  assign seg_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      segcnt_q <= '0;
      mss_q    <= CNT_W'(1);
      idx_q    <= '0;
    end else if (load) begin
      rem_q    <= total_i;
      segcnt_q <= '0;
      mss_q    <= mss_i;
      idx_q    <= '0;
    end else if (pay_fire) begin
      rem_q <= rem_q - CNT_W'(1);
      if (seg_end) begin
        segcnt_q <= '0;
        idx_q    <= idx_q + IDX_W'(1);
      end else begin
        segcnt_q <= segcnt_q + CNT_W'(1);
      end
    end
  end

  // R3: bytes sent in the current segment stay below the segment size
  a_r3_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) || (segcnt_q < mss_q));

  // R6: segment index only moves when a segment closes or a job loads
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(pay_fire && seg_end)) |=> $stable(idx_q));
endmodule

// File: rtl/shr_ctrl.sv
module shr_ctrl
  import shr_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ok,
  input  logic [LEN_W-1:0] hdr_len_i,
  input  logic             tot_zero_i,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             out_ready,
  input  logic             seg_end,
  input  logic             job_end,
  input  logic             job_empty,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_sof,
  output logic             pay_sel,
  output logic             pay_fire,
  output logic             job_load,
  output logic             wr_en,
  output logic [LEN_W-1:0] wr_ptr,
  output logic [LEN_W-1:0] rd_ptr,
  output logic             idle
);
  shr_state_t st_q, st_n;
  logic [LEN_W-1:0] hptr_q, hptr_n, hlen_q;

  always_comb begin
    st_n      = st_q;
    hptr_n    = hptr_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_sof   = 1'b0;
    pay_sel   = 1'b0;
    pay_fire  = 1'b0;
    job_load  = 1'b0;
    wr_en     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        in_ready = cfg_ok;
        if (cfg_ok && in_valid && in_first) begin
          wr_en    = 1'b1;
          job_load = 1'b1;
          if (hdr_len_i == LEN_W'(1)) begin
            hptr_n = '0;
            st_n   = tot_zero_i ? ST_IDLE : ST_HDR;
          end else begin
            hptr_n = LEN_W'(1);
            st_n   = ST_CAPT;
          end
        end
      end
      ST_CAPT: begin
        in_ready = 1'b1;
        if (in_valid) begin
          wr_en = 1'b1;
          if (hptr_q == hlen_q - LEN_W'(1)) begin
            hptr_n = '0;
            st_n   = job_empty ? ST_IDLE : ST_HDR;
          end else begin
            hptr_n = hptr_q + LEN_W'(1);
          end
        end
      end
      ST_HDR: begin
        out_valid = 1'b1;
        out_sof   = (hptr_q == '0);
        if (out_ready) begin
          if (hptr_q == hlen_q - LEN_W'(1)) begin
            hptr_n = '0;
            st_n   = ST_PAY;
          end else begin
            hptr_n = hptr_q + LEN_W'(1);
          end
        end
      end
      ST_PAY: begin
        pay_sel   = 1'b1;
        out_valid = in_valid;
        in_ready  = out_ready;
        if (in_valid && out_ready) begin
          pay_fire = 1'b1;
          if (seg_end) st_n = job_end ? ST_IDLE : ST_HDR;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hptr_q <= '0;
      hlen_q <= LEN_W'(1);
    end else begin
      st_q   <= st_n;
      hptr_q <= hptr_n;
      if (job_load) hlen_q <= hdr_len_i;
    end
  end

  assign wr_ptr = (st_q == ST_IDLE) ? '0 : hptr_q;
  assign rd_ptr = hptr_q;
  assign idle   = (st_q == ST_IDLE);

  // R5: no payload is taken while the header is replayed
  a_r5_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> !in_ready);

  // R2: a frame start is followed by a non-start byte
  a_r2_sof_once: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_sof) |=> !out_sof);

  // R8: the final payload byte of a job returns the block to idle
  a_r8_job_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_fire && seg_end && job_end) |=> (st_q == ST_IDLE));

  // R1: capture never drives the output
  a_r1_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT) |-> !out_valid);
endmodule

// File: rtl/seg_hdr_replay.sv
module seg_hdr_replay #(
  parameter int HDR_MAX = 128,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = 8,
  localparam int LEN_W  = $clog2(HDR_MAX + 1),
  localparam int MAW    = (HDR_MAX > 1) ? $clog2(HDR_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_hdr_len,
  input  logic [CNT_W-1:0] cfg_mss,
  input  logic [CNT_W-1:0] cfg_total,
  output logic             cfg_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [IDX_W-1:0] out_seg_idx,
  output logic             out_last_seg
);
  logic             cfg_ok, pay_sel, pay_fire, job_load, wr_en, idle;
  logic             seg_end, job_end, job_empty;
  logic [LEN_W-1:0] wr_ptr, rd_ptr;
  logic [7:0]       hdr_byte;

  assign cfg_ok  = (cfg_hdr_len != '0) && (cfg_hdr_len <= LEN_W'(HDR_MAX))
                   && (cfg_mss != '0);
  assign cfg_err = !cfg_ok;

  shr_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .hdr_len_i(cfg_hdr_len),
    .tot_zero_i(cfg_total == '0), .in_valid(in_valid), .in_first(in_first),
    .out_ready(out_ready), .seg_end(seg_end), .job_end(job_end),
    .job_empty(job_empty), .in_ready(in_ready), .out_valid(out_valid),
    .out_sof(out_sof), .pay_sel(pay_sel), .pay_fire(pay_fire),
    .job_load(job_load), .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .idle(idle)
  );

  shr_hdr_mem #(.DEPTH(HDR_MAX), .DW(8)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr[MAW-1:0]), .wr_data(in_data),
    .rd_addr(rd_ptr[MAW-1:0]), .rd_data(hdr_byte)
  );

  shr_seg_track #(.CNT_W(CNT_W), .IDX_W(IDX_W)) track_i (
    .clk(clk), .rst_n(rst_n), .load(job_load), .mss_i(cfg_mss),
    .total_i(cfg_total), .pay_fire(pay_fire), .seg_end(seg_end),
    .job_end(job_end), .job_empty(job_empty), .last_seg(out_last_seg),
    .seg_idx(out_seg_idx)
  );

  assign out_data = pay_sel ? in_data : hdr_byte;
  assign out_eof  = pay_sel && seg_end;

  // R9: a stalled header byte is held steady
  a_r9_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pay_sel) |=> (out_valid && $stable(out_data)));

  // R7: a bad configuration blocks job start while idle
  a_r7_err_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && idle) |-> !in_ready);

  // R3: frame end only appears on a payload byte
  a_r3_eof_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> !out_sof);
endmodule

// File: tb/seg_hdr_replay_tb_top.sv
module seg_hdr_replay_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_hdr_len = 8'd2;
  logic [15:0] cfg_mss = 16'd2;
  logic [15:0] cfg_total = 16'd0;
  logic        cfg_err;
  logic        in_valid = 1'b0, in_first = 1'b0, in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid, out_sof, out_eof, out_last_seg;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data, out_seg_idx;

  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] s_data [64];
  logic       s_first [64];
  logic [7:0] e_data [64];
  logic       e_sof [64], e_eof [64], e_last [64];
  int         e_idx [64];

  always #2.5 clk = ~clk;

  seg_hdr_replay dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_hdr_len(cfg_hdr_len), .cfg_mss(cfg_mss),
    .cfg_total(cfg_total), .cfg_err(cfg_err), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_seg_idx(out_seg_idx),
    .out_last_seg(out_last_seg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int h, input int m, input int t, input int junk, input int job);
    int slen, n, nseg, ipos, opos, cyc;
    bit took, pstall;
    logic [7:0] pdata;
    slen = 0;
    for (int j = 0; j < junk; j++) begin s_data[slen] = 8'h55; s_first[slen] = 1'b0; slen++; end
    for (int i = 0; i < h; i++) begin s_data[slen] = 8'(8'hC0 + i + job); s_first[slen] = (i == 0); slen++; end
    for (int k = 0; k < t; k++) begin s_data[slen] = 8'(k * 13 + job * 3); s_first[slen] = 1'b0; slen++; end
    nseg = (t == 0) ? 0 : (t + m - 1) / m;
    n = 0;
    for (int s = 0; s < nseg; s++) begin
      int sl;
      sl = (t - s * m < m) ? t - s * m : m;
      for (int i = 0; i < h; i++) begin
        e_data[n] = 8'(8'hC0 + i + job); e_sof[n] = (i == 0); e_eof[n] = 1'b0;
        e_idx[n] = s; e_last[n] = (s == nseg - 1); n++;
      end
      for (int k = 0; k < sl; k++) begin
        e_data[n] = 8'((s * m + k) * 13 + job * 3); e_sof[n] = 1'b0; e_eof[n] = (k == sl - 1);
        e_idx[n] = s; e_last[n] = (s == nseg - 1); n++;
      end
    end
    cfg_hdr_len = 8'(h); cfg_mss = 16'(m); cfg_total = 16'(t);
    ipos = 0; opos = 0; cyc = 0; took = 0; pstall = 0; pdata = '0;
    while ((ipos < slen || opos < n) && cyc < 3000) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!in_valid || took) begin
        took = 0;
        if (ipos < slen && (lfsr[0] | lfsr[3])) begin
          in_valid = 1'b1; in_data = s_data[ipos]; in_first = s_first[ipos];
        end else begin
          in_valid = 1'b0; in_first = 1'b0;
        end
      end
      out_ready = lfsr[1] | lfsr[5];
      #1;
      if (pstall) chk(out_valid && out_data == pdata, "R9 stall hold", int'(out_data), int'(pdata));
      if (out_valid) begin
        chk(ipos >= junk + h, "R1 header withheld", ipos, junk + h);
        if (out_sof) chk(!in_ready, "R5 input held in replay", int'(in_ready), 0);
      end
      if (out_valid && out_ready) begin
        if (opos >= n) chk(0, "R8 extra output byte", opos, n);
        else begin
          chk(out_data == e_data[opos], "R4 data order", int'(out_data), int'(e_data[opos]));
          chk(out_sof == e_sof[opos], "R2 sof", int'(out_sof), int'(e_sof[opos]));
          chk(out_eof == e_eof[opos], "R3 eof", int'(out_eof), int'(e_eof[opos]));
          chk(int'(out_seg_idx) == e_idx[opos], "R6 seg index", int'(out_seg_idx), e_idx[opos]);
          chk(out_last_seg == e_last[opos], "R6 last seg", int'(out_last_seg), int'(e_last[opos]));
        end
        opos++;
      end
      pstall = out_valid && !out_ready;
      pdata = out_data;
      if (in_valid && in_ready) begin ipos++; took = 1; end
      cyc++;
    end
    chk(cyc < 3000, "R8 job completion", cyc, 3000);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; out_ready = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R8 idle after job", int'({out_valid, in_ready}), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hl [4];
    int ml [5];
    int job;
    hl = '{1, 2, 3, 5};
    ml = '{1, 2, 3, 4, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid && in_ready && !cfg_err, "R11 reset state", int'({out_valid, in_ready, cfg_err}), 2);

    cfg_hdr_len = 8'd0; #1;
    chk(cfg_err && !in_ready, "R7 zero header length", int'({cfg_err, in_ready}), 2);
    cfg_hdr_len = 8'd129; #1;
    chk(cfg_err && !in_ready, "R7 header length over 128", int'({cfg_err, in_ready}), 2);
    cfg_hdr_len = 8'd128; cfg_mss = 16'd0; #1;
    chk(cfg_err && !in_ready, "R7 zero segment size", int'({cfg_err, in_ready}), 2);
    in_valid = 1'b1; in_first = 1'b1; in_data = 8'h11; cfg_total = 16'd3;
    repeat (4) begin
      @(negedge clk); #1;
      chk(!out_valid && !in_ready, "R7 no job under error", int'(out_valid), 0);
    end
    in_valid = 1'b0; in_first = 1'b0; cfg_mss = 16'd2; #1;
    chk(!cfg_err && in_ready, "R7 error clears", int'(cfg_err), 0);

    job = 0;
    foreach (hl[a]) foreach (ml[b]) for (int t = 0; t < 10; t++) begin
      run_job(hl[a], ml[b], t, (job % 3 == 0) ? 2 : 0, job); // R10 junk on every third job
      job++;
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule